// File: doc/BRIEF.md
# Eight-Input Weighted Fair Queueing Scheduler Node

This block is a single scheduling node that chooses which of eight traffic inputs sends next. Each input presents a backlog flag, the length of its head packet and the result of an external rate shaper. A configuration port sets, for each input, an enable bit, a 10-bit weight and a flag that says whether a shaper governs that input. An input takes part in the choice only when it is enabled, has a packet waiting and, if a shaper governs it, the shaper result lets it pass.

Inputs with weight zero form a strict-priority class. They beat every weighted input, and among themselves the lowest input number wins. All other inputs share the link by weighted fair queueing. Each one keeps a virtual departure time, and the smallest time wins. When the downstream stage takes a packet with the dequeue strobe, the winner's time moves forward by its packet length times its weight. The node's own virtual time follows the start time of each weighted winner. An input that has no backlog, or is disabled, is kept level with that node time, so a flow that returns does not bring old credit with it. If an advance does not fit in the time register, a sticky error flag rises.

Top module: `wfq_node`

## Requirements
- R1: After reset, out_filled is 0, out_leaf is 0 and vt_err is 0. Every input is disabled, has weight 0, has no shaper assigned and has a virtual time of 0.
- R2: When cfg_we is high at a rising edge, the input selected by cfg_idx (0..7) loads cfg_en, cfg_wgt and cfg_shp. The new values steer selection from the next cycle on.
- R3: An input is eligible only when it is enabled, in_valid is high for it, and either no shaper is assigned to it or its in_pass bit is high.
- R4: An eligible input with weight 0 wins over every eligible input with a nonzero weight.
- R5: When several eligible inputs have weight 0, the lowest input number wins.
- R6: When no weight-0 input is eligible, the eligible input with the lowest virtual time wins. On a tie, the lower input number wins.
- R7: At a rising edge with deq high and out_filled high, the winner's virtual time grows by its packet length times its weight. If the winner is weighted, the node virtual time takes the winner's value from before that advance.
- R8: While an input is disabled or has no backlog, its virtual time is reloaded from the node virtual time at every edge. A new backlog therefore starts level with the node.
- R9: out_filled is high exactly when at least one input is eligible. In that case out_leaf gives the winner in the same cycle, with no register in the path.
- R10: While out_filled is low, out_leaf holds the last winner index it reported, or 0 if there has been none since reset.
- R11: If an advance would exceed the virtual-time width (24 bits), vt_err rises at that edge and stays high until reset. The input's time saturates at its maximum.
- R12: Disabling an eligible input through the configuration port removes it from the choice in the next cycle. Enabling it again returns it to the choice in the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Input number the write targets |
| cfg_en | input | 1 | Enable bit to store |
| cfg_wgt | input | 10 | Weight to store; 0 means strict priority |
| cfg_shp | input | 1 | Shaper-assigned flag to store |
| in_valid | input | 8 | Backlog flag, one bit per input |
| in_len | input | 112 | Head packet length, 14 bits per input, input i at bits [14i+13:14i] |
| in_pass | input | 8 | Shaper pass result, one bit per input |
| deq | input | 1 | Dequeue strobe from the downstream stage |
| out_filled | output | 1 | At least one input is eligible |
| out_leaf | output | 3 | Winning input number |
| vt_err | output | 1 | Sticky virtual-time overflow flag |

## Verification
The main choice is tried with several backlog patterns. Two strict inputs backlogged together show that the lower number wins. Three weighted inputs with weights 1, 3 and 2, drained over many dequeues, show that selection follows the accumulated virtual times and that ties go to the lower number. A strict input that joins in the middle of a weighted run shows that it pre-empts the weighted inputs without disturbing their times. A shaper-gated input that is backlogged but blocked shows the difference between having a packet and being eligible. The weighted inputs coming back after an idle gap show that a returning flow restarts at the node time and does not keep its old, smaller time. Directed runs then cover disabling and re-enabling an input, and two large dequeues that overflow the time register.

// File: rtl/wfq_pkg.sv
package wfq_pkg;

    localparam int NODE_INPUTS = 8;
    localparam int WEIGHT_W    = 10;
    localparam int PKT_LEN_W   = 14;
    localparam int VTIME_W     = 24;

    typedef enum logic [1:0] {
        PICK_NONE   = 2'd0,
        PICK_STRICT = 2'd1,
        PICK_WFQ    = 2'd2
    } pick_kind_e;

    function automatic logic slot_eligible(input logic en, input logic backlog,
                                           input logic shaped, input logic pass);
        return en && backlog && (!shaped || pass);
    endfunction

endpackage

// File: rtl/wfq_input_slot.sv
module wfq_input_slot
    import wfq_pkg::*;
#(
    parameter int LEN_W = PKT_LEN_W,
    parameter int WGT_W = WEIGHT_W,
    parameter int VT_W  = VTIME_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_hit,
    input  logic             cfg_en,
    input  logic [WGT_W-1:0] cfg_wgt,
    input  logic             cfg_shp,
    input  logic             valid,
    input  logic [LEN_W-1:0] len,
    input  logic             shp_pass,
    input  logic [VT_W-1:0]  vnow,
    input  logic             adv,
    output logic             elig,
    output logic             strict,
    output logic [VT_W-1:0]  vdt,
    output logic             ovf
);
    localparam int PROD_W = LEN_W + WGT_W;

    logic             en_q;
    logic [WGT_W-1:0] wgt_q;
    logic             shp_q;
    logic [VT_W-1:0]  vdt_q;
    logic [PROD_W-1:0] cost;
    logic [VT_W:0]    sum;

    assign cost   = PROD_W'(len) * PROD_W'(wgt_q);
    assign sum    = {1'b0, vdt_q} + (VT_W + 1)'(cost);
    assign elig   = slot_eligible(en_q, valid, shp_q, shp_pass);
    assign strict = (wgt_q == '0);
    assign vdt    = vdt_q;
    assign ovf    = adv && sum[VT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            wgt_q <= '0;
            shp_q <= 1'b0;
            vdt_q <= '0;
        end else begin
            if (cfg_hit) begin
                en_q  <= cfg_en;
                wgt_q <= cfg_wgt;
                shp_q <= cfg_shp;
            end
            if (!(en_q && valid)) begin
                vdt_q <= vnow;
            end else if (adv) begin
                vdt_q <= sum[VT_W] ? '1 : sum[VT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/wfq_arbiter.sv
module wfq_arbiter
    import wfq_pkg::*;
#(
    parameter int N_IN = NODE_INPUTS,
    parameter int VT_W = VTIME_W,
    localparam int IW  = $clog2(N_IN)
) (
    input  logic [N_IN-1:0] elig,
    input  logic [N_IN-1:0] strict,
    input  logic [VT_W-1:0] vdt_a [N_IN],
    output pick_kind_e      kind,
    output logic [IW-1:0]   idx
);
    logic [VT_W-1:0] best;

    always_comb begin
        kind = PICK_NONE;
        idx  = '0;
        best = '1;
        for (int i = 0; i < N_IN; i++) begin
            if (elig[i] && strict[i] && kind != PICK_STRICT) begin
                kind = PICK_STRICT;
                idx  = IW'(i);
            end
        end
        if (kind == PICK_NONE) begin
            for (int i = 0; i < N_IN; i++) begin
                if (elig[i] && !strict[i] && (kind == PICK_NONE || vdt_a[i] < best)) begin
                    kind = PICK_WFQ;
                    idx  = IW'(i);
                    best = vdt_a[i];
                end
            end
        end
    end

endmodule

// File: rtl/wfq_node.sv
module wfq_node
    import wfq_pkg::*;
#(
    parameter int N_IN  = NODE_INPUTS,
    parameter int WGT_W = WEIGHT_W,
    parameter int LEN_W = PKT_LEN_W,
    parameter int VT_W  = VTIME_W,
    localparam int IW   = $clog2(N_IN)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [IW-1:0]         cfg_idx,
    input  logic                  cfg_en,
    input  logic [WGT_W-1:0]      cfg_wgt,
    input  logic                  cfg_shp,
    input  logic [N_IN-1:0]       in_valid,
    input  logic [N_IN*LEN_W-1:0] in_len,
    input  logic [N_IN-1:0]       in_pass,
    input  logic                  deq,
    output logic                  out_filled,
    output logic [IW-1:0]         out_leaf,
    output logic                  vt_err
);
    logic [N_IN-1:0] elig;
    logic [N_IN-1:0] strict;
    logic [N_IN-1:0] ovf;
    logic [VT_W-1:0] vdt_a [N_IN];
    logic [VT_W-1:0] vnow_q;
    logic [IW-1:0]   leaf_q;
    logic            err_q;
    pick_kind_e      kind;
    logic [IW-1:0]   win_idx;
    logic            take;

    assign take = deq && (kind != PICK_NONE);

    for (genvar g = 0; g < N_IN; g++) begin : g_slot
        wfq_input_slot #(
            .LEN_W(LEN_W),
            .WGT_W(WGT_W),
            .VT_W (VT_W)
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .cfg_hit (cfg_we && (cfg_idx == IW'(g))),
            .cfg_en  (cfg_en),
            .cfg_wgt (cfg_wgt),
            .cfg_shp (cfg_shp),
            .valid   (in_valid[g]),
            .len     (in_len[g*LEN_W +: LEN_W]),
            .shp_pass(in_pass[g]),
            .vnow    (vnow_q),
            .adv     (take && (win_idx == IW'(g))),
            .elig    (elig[g]),
            .strict  (strict[g]),
            .vdt     (vdt_a[g]),
            .ovf     (ovf[g])
        );
    end

    wfq_arbiter #(
        .N_IN(N_IN),
        .VT_W(VT_W)
    ) u_arb (
        .elig  (elig),
        .strict(strict),
        .vdt_a (vdt_a),
        .kind  (kind),
        .idx   (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vnow_q <= '0;
            leaf_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (kind != PICK_NONE) leaf_q <= win_idx;
            if (take && kind == PICK_WFQ) vnow_q <= vdt_a[win_idx];
            if (|ovf) err_q <= 1'b1;
        end
    end

    assign out_filled = (kind != PICK_NONE);
    assign out_leaf   = out_filled ? win_idx : leaf_q;
    assign vt_err     = err_q;

endmodule

// File: rtl/wfq_node_chk.sv
module wfq_node_chk #(
    parameter int N_IN = 8,
    localparam int IW  = $clog2(N_IN)
) (
    input logic            clk,
    input logic            rst,
    input logic [N_IN-1:0] in_valid,
    input logic            out_filled,
    input logic [IW-1:0]   out_leaf,
    input logic            vt_err,
    input logic [N_IN-1:0] elig,
    input logic [N_IN-1:0] strict
);
    logic            started;
    logic [N_IN-1:0] below;

    assign below = (N_IN'(1) << out_leaf) - N_IN'(1);

    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !(|in_valid) |-> !out_filled); // R3
    AST_FILLED_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_filled == (|elig)); // R9
    AST_WIN_ELIG: assert property (@(posedge clk) disable iff (rst)
        out_filled |-> (elig[out_leaf] && in_valid[out_leaf])); // R9
    AST_STRICT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (out_filled && |(elig & strict)) |-> strict[out_leaf]); // R4
    AST_STRICT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (out_filled && strict[out_leaf]) |-> ((elig & strict & below) == '0)); // R5
    AST_LEAF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (started && !out_filled) |-> (out_leaf == $past(out_leaf))); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        vt_err |=> vt_err); // R11

endmodule

bind wfq_node wfq_node_chk #(.N_IN(N_IN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_filled(out_filled),
    .out_leaf  (out_leaf),
    .vt_err    (vt_err),
    .elig      (elig),
    .strict    (strict)
);

// File: tb/wfq_node_bench.sv
module wfq_node_bench;
    localparam int N = 8;
    localparam int LW = 14;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic          cfg_en = 1'b0;
    logic [9:0]    cfg_wgt = '0;
    logic          cfg_shp = 1'b0;
    logic [N-1:0]  in_valid = '0;
    logic [N*LW-1:0] in_len = '0;
    logic [N-1:0]  in_pass = '0;
    logic          deq = 1'b0;
    logic          out_filled;
    logic [2:0]    out_leaf;
    logic          vt_err;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    wfq_node u_wfq_node (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_wgt(cfg_wgt), .cfg_shp(cfg_shp),
        .in_valid(in_valid), .in_len(in_len), .in_pass(in_pass), .deq(deq),
        .out_filled(out_filled), .out_leaf(out_leaf), .vt_err(vt_err)
    );

    // vector: {valid[7:0], pass[7:0], deq, exp_filled, exp_leaf[2:0]}
    // weights: in0=0 in1=0 in2=1 in3=3 in4=2 in5=5 in6=7 in7=1 (shaped); all lengths 10
    localparam logic [20:0] VEC [NV] = '{
        {8'h00, 8'h00, 1'b0, 1'b0, 3'd0}, // R10 idle after reset holds 0
        {8'h03, 8'h00, 1'b1, 1'b1, 3'd0}, // R5 two strict, lowest wins
        {8'h02, 8'h00, 1'b1, 1'b1, 3'd1}, // R4 strict alone
        {8'h1C, 8'h00, 1'b1, 1'b1, 3'd2}, // R6 tie at 0 -> lowest
        {8'h1C, 8'h00, 1'b1, 1'b1, 3'd3}, // R7 in2 advanced to 10
        {8'h1C, 8'h00, 1'b1, 1'b1, 3'd4}, // R6
        {8'h1C, 8'h00, 1'b1, 1'b1, 3'd2}, // R7 10,30,20
        {8'h1C, 8'h00, 1'b1, 1'b1, 3'd2}, // R6 tie 20,20 -> in2
        {8'h1C, 8'h00, 1'b1, 1'b1, 3'd4}, // R6 30,30,20
        {8'h1C, 8'h00, 1'b1, 1'b1, 3'd2}, // R6 30,30,40
        {8'h1D, 8'h00, 1'b1, 1'b1, 3'd0}, // R4 strict pre-empts
        {8'h1C, 8'h00, 1'b1, 1'b1, 3'd3}, // R6 40,30,40
        {8'h80, 8'h00, 1'b0, 1'b0, 3'd3}, // R3 shaper blocks; R10 hold 3
        {8'h80, 8'h80, 1'b1, 1'b1, 3'd7}, // R3 shaper passes
        {8'h9C, 8'h80, 1'b1, 1'b1, 3'd2}, // R8 returning flows restart at 30
        {8'h9C, 8'h80, 1'b1, 1'b1, 3'd3}  // R8 in2=40 in3=30 in4=30 in7=40
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic en, input int wgt, input logic shp);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_en = en; cfg_wgt = 10'(wgt); cfg_shp = shp;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; in_valid = '0; deq = 1'b0; cfg_we = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) in_len[i*LW +: LW] = 14'd10;
        do_reset();
        @(negedge clk);
        check("R1 filled", 32'(out_filled), 0);
        check("R1 leaf", 32'(out_leaf), 0);
        check("R1 err", 32'(vt_err), 0);
        in_valid = 8'hFF; in_pass = 8'hFF;
        @(negedge clk);
        check("R1 inputs disabled", 32'(out_filled), 0);
        @(posedge clk); #1;
        in_valid = '0; in_pass = '0;

        cfg_write(0, 1'b1, 0, 1'b0);
        cfg_write(1, 1'b1, 0, 1'b0);
        cfg_write(2, 1'b1, 1, 1'b0);
        cfg_write(3, 1'b1, 3, 1'b0);
        cfg_write(4, 1'b1, 2, 1'b0);
        cfg_write(5, 1'b1, 5, 1'b0);
        cfg_write(6, 1'b1, 7, 1'b0);
        cfg_write(7, 1'b1, 1, 1'b1); // R2 shaper assigned

        for (int v = 0; v < NV; v++) begin
            in_valid = VEC[v][20:13];
            in_pass  = VEC[v][12:5];
            deq      = VEC[v][4];
            @(negedge clk);
            check($sformatf("R9 vec%0d filled", v), 32'(out_filled), 32'(VEC[v][3]));
            check($sformatf("R6 vec%0d leaf", v), 32'(out_leaf), 32'(VEC[v][2:0]));
            @(posedge clk); #1;
        end
        deq = 1'b0;

        // R12: disable strict in0 while in2 waits, then re-enable
        in_valid = 8'h05; in_pass = '0;
        @(negedge clk);
        check("R12 before disable", 32'(out_leaf), 0);
        cfg_write(0, 1'b0, 0, 1'b0);
        @(negedge clk);
        check("R12 disabled removed", 32'(out_leaf), 2);
        cfg_write(0, 1'b1, 0, 1'b0);
        @(negedge clk);
        check("R12 re-enabled", 32'(out_leaf), 0);
        cfg_write(0, 1'b1, 4, 1'b0); // R2 weight change to nonzero
        @(negedge clk);
        check("R2 weight now nonzero", 32'(out_leaf), 0);
        @(posedge clk); #1;

        // R11: overflow with weight 1023 and length 16383
        do_reset();
        cfg_write(5, 1'b1, 1023, 1'b0);
        in_len[5*LW +: LW] = 14'h3FFF;
        in_valid = 8'h20; deq = 1'b1;
        @(negedge clk);
        check("R11 leaf", 32'(out_leaf), 5);
        @(posedge clk); #1;
        @(negedge clk);
        check("R11 no overflow yet", 32'(vt_err), 0);
        @(posedge clk); #1;
        deq = 1'b0;
        @(negedge clk);
        check("R11 overflow flagged", 32'(vt_err), 1);
        in_valid = '0;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk);
        check("R11 sticky", 32'(vt_err), 1);
        check("R10 leaf held", 32'(out_leaf), 5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule